// File: doc/BRIEF.md
# Fetch/Execute Control Sequencer

This block is the control unit of a small accumulator machine. It runs as a two-phase loop. In the fetch phase it drives the program counter onto the address bus, loads the instruction register, and advances the program counter through the ALU's B-increment path. In the execute phase it decodes the 4-bit opcode held in the instruction register and sets the address source, the ALU operand and function, the accumulator source, the register load enables, the accumulator bus drive and the memory strobes. The execute phase may also use the accumulator's sign and zero flags. The datapath registers, the ALU and the memory sit outside the block.

All pins are plain control pins. No data passes through the block, so it has no valid/ready handshake. An active-high asynchronous reset puts the block in a clear state, which pulses the register-clear output for one cycle before the first fetch. A halt opcode moves the block to an absorbing stop state that only reset leaves.

Top module: `cpu_seq_ctrl`

## Requirements
- R1: While `rst` is high, the block asserts `clr` and keeps `mem_req` low, with every load enable and `acc_oe` low. Raising `rst` has this effect at once, without waiting for a clock.
- R2: After reset is released, `clr` stays high for exactly one cycle, and the fetch phase follows on the next cycle.
- R3: In fetch, the outputs are `addr_sel`=00 (PC), `alub_sel`=0 (zero-extended address), `alu_fn`=000 (B+1), `ir_ld`=1, `pc_ld`=1, `mem_req`=1 and `rd_nwr`=1. All other enables are low.
- R4: Every execute phase of an opcode other than halt is followed by a fetch phase.
- R5: Opcodes 0000 (load), 0010 (add), 0011 (subtract), 1000 (and), 1001 (or) and 1010 (xor) drive `addr_sel`=11 (IR address field), `alub_sel`=1 (memory data), `acc_src_sel`=0 and `acc_ld`=1. They drive `alu_fn` 001 (pass B), 010, 011, 100, 101 and 110 respectively.
- R6: Opcode 0001 (store) drives `addr_sel`=11, `acc_oe`=1, `rd_nwr`=0 and `mem_req`=1, with no load enable asserted.
- R7: Opcodes 0100 (jump), 0101 (jump if sign clear) and 0110 (jump if non-zero) drive `addr_sel`=11, `alub_sel`=0 and `alu_fn`=001. `pc_ld` is asserted always for 0100, only when `acc_neg`=0 for 0101, and only when `acc_zero`=0 for 0110.
- R8: Opcode 1011 loads R from the IR address field: `addr_sel`=11, `alub_sel`=0, `alu_fn`=001 and `r_ld`=1.
- R9: Opcode 1100 drives `addr_sel`=01 (R), `acc_src_sel`=1, `acc_ld`=1, `r_ld`=1, `alub_sel`=0 and `alu_fn`=000. Opcode 1101 drives `addr_sel`=01, `acc_oe`=1, `rd_nwr`=0, `r_ld`=1 and `alu_fn`=000.
- R10: Opcode 0111 (halt) drives `mem_req` low in its execute phase and then enters stop. Stop keeps `mem_req` low and every enable low, whatever `opcode`, `acc_neg` and `acc_zero` do.
- R11: Opcodes 1110 and 1111 assert no enable and keep `mem_req`=1 and `rd_nwr`=1. They then return to fetch.
- R12: `addr_sel` never takes the unused code 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| opcode | input | 4 | Opcode field of the instruction register |
| acc_neg | input | 1 | Accumulator sign bit |
| acc_zero | input | 1 | Accumulator equals zero |
| addr_sel | output | 2 | Address source: 00 PC, 01 R, 11 IR address |
| alub_sel | output | 1 | ALU B operand: 0 zero-extended address, 1 memory data |
| acc_src_sel | output | 1 | Accumulator source: 0 ALU, 1 memory data |
| acc_ld | output | 1 | Accumulator load |
| pc_ld | output | 1 | Program counter load |
| r_ld | output | 1 | Index register load |
| ir_ld | output | 1 | Instruction register load |
| acc_oe | output | 1 | Accumulator drives the data bus |
| alu_fn | output | 3 | ALU function code |
| mem_req | output | 1 | Memory access request |
| rd_nwr | output | 1 | 1 read, 0 write |
| clr | output | 1 | Register clear pulse |

## Verification
The bench runs each of the sixteen opcode codes through a fetch/execute pair and compares the whole control word in both phases. This shows that each opcode has its own decode, and that fetch does not depend on the opcode.

Each conditional jump is tried with all the flag combinations that matter. These include a set zero flag on the sign-tested jump and a set sign flag on the zero-tested jump, which catches a swapped flag or an inverted condition.

Halt is followed by changes to the opcode and flags, to show that the stop state does not react. Reset is raised in the middle of an execute phase and in stop, to show that it acts asynchronously and restarts with the clear pulse.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int OP_W   = 4;
  localparam int ASEL_W = 2;
  localparam int FN_W   = 3;

  typedef enum logic [1:0] {
    ST_INIT  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EXEC  = 2'd2,
    ST_STOP  = 2'd3
  } seq_state_t;

  localparam logic [OP_W-1:0] OP_LDA = 4'h0;
  localparam logic [OP_W-1:0] OP_STO = 4'h1;
  localparam logic [OP_W-1:0] OP_ADD = 4'h2;
  localparam logic [OP_W-1:0] OP_SUB = 4'h3;
  localparam logic [OP_W-1:0] OP_JMP = 4'h4;
  localparam logic [OP_W-1:0] OP_JGE = 4'h5;
  localparam logic [OP_W-1:0] OP_JNE = 4'h6;
  localparam logic [OP_W-1:0] OP_HLT = 4'h7;
  localparam logic [OP_W-1:0] OP_AND = 4'h8;
  localparam logic [OP_W-1:0] OP_IOR = 4'h9;
  localparam logic [OP_W-1:0] OP_XOR = 4'hA;
  localparam logic [OP_W-1:0] OP_LDR = 4'hB;
  localparam logic [OP_W-1:0] OP_LDI = 4'hC;
  localparam logic [OP_W-1:0] OP_STI = 4'hD;

  localparam logic [ASEL_W-1:0] AS_PC   = 2'b00;
  localparam logic [ASEL_W-1:0] AS_REG  = 2'b01;
  localparam logic [ASEL_W-1:0] AS_NONE = 2'b10;
  localparam logic [ASEL_W-1:0] AS_IRA  = 2'b11;

  localparam logic [FN_W-1:0] FN_BINC  = 3'd0;
  localparam logic [FN_W-1:0] FN_PASSB = 3'd1;
  localparam logic [FN_W-1:0] FN_ADD   = 3'd2;
  localparam logic [FN_W-1:0] FN_SUB   = 3'd3;
  localparam logic [FN_W-1:0] FN_AND   = 3'd4;
  localparam logic [FN_W-1:0] FN_OR    = 3'd5;
  localparam logic [FN_W-1:0] FN_XOR   = 3'd6;

  typedef struct packed {
    logic [ASEL_W-1:0] asel;
    logic              bsel;
    logic              asrc;
    logic              acc_ld;
    logic              pc_ld;
    logic              r_ld;
    logic              ir_ld;
    logic              acc_oe;
    logic [FN_W-1:0]   fn;
    logic              mreq;
    logic              rnw;
    logic              clr;
  } ctl_t;

  // Baseline word: a memory read at the PC with B+1 and nothing loaded.
  function automatic ctl_t ctl_idle();
    ctl_t w;
    w.asel   = AS_PC;
    w.bsel   = 1'b0;
    w.asrc   = 1'b0;
    w.acc_ld = 1'b0;
    w.pc_ld  = 1'b0;
    w.r_ld   = 1'b0;
    w.ir_ld  = 1'b0;
    w.acc_oe = 1'b0;
    w.fn     = FN_BINC;
    w.mreq   = 1'b1;
    w.rnw    = 1'b1;
    w.clr    = 1'b0;
    return w;
  endfunction
endpackage

// File: rtl/seq_state.sv
module seq_state
  import seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] op,
  output seq_state_t      state
);
  seq_state_t nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_INIT:  nxt = ST_FETCH;
      ST_FETCH: nxt = ST_EXEC;
      ST_EXEC:  nxt = (op == OP_HLT) ? ST_STOP : ST_FETCH;
      ST_STOP:  nxt = ST_STOP;
      default:  nxt = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state <= ST_INIT;
    else     state <= nxt;
  end
endmodule

// File: rtl/seq_cond.sv
module seq_cond
  import seq_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic            neg,
  input  logic            zero,
  output logic            take
);
  always_comb begin
    case (op)
      OP_JMP:  take = 1'b1;
      OP_JGE:  take = ~neg;
      OP_JNE:  take = ~zero;
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/seq_exec_dec.sv
module seq_exec_dec
  import seq_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic            take,
  output ctl_t            w
);
  always_comb begin
    w = ctl_idle();
    case (op)
      OP_LDA, OP_ADD, OP_SUB, OP_AND, OP_IOR, OP_XOR: begin
        w.asel   = AS_IRA;
        w.bsel   = 1'b1;
        w.acc_ld = 1'b1;
        case (op)
          OP_ADD:  w.fn = FN_ADD;
          OP_SUB:  w.fn = FN_SUB;
          OP_AND:  w.fn = FN_AND;
          OP_IOR:  w.fn = FN_OR;
          OP_XOR:  w.fn = FN_XOR;
          default: w.fn = FN_PASSB;
        endcase
      end
      OP_STO: begin
        w.asel   = AS_IRA;
        w.acc_oe = 1'b1;
        w.rnw    = 1'b0;
      end
      OP_JMP, OP_JGE, OP_JNE: begin
        w.asel  = AS_IRA;
        w.fn    = FN_PASSB;
        w.pc_ld = take;
      end
      OP_LDR: begin
        w.asel = AS_IRA;
        w.fn   = FN_PASSB;
        w.r_ld = 1'b1;
      end
      OP_LDI: begin
        w.asel   = AS_REG;
        w.asrc   = 1'b1;
        w.acc_ld = 1'b1;
        w.r_ld   = 1'b1;
      end
      OP_STI: begin
        w.asel   = AS_REG;
        w.acc_oe = 1'b1;
        w.rnw    = 1'b0;
        w.r_ld   = 1'b1;
      end
      OP_HLT: begin
        w.mreq = 1'b0;
      end
      default: begin
        w = ctl_idle();
      end
    endcase
  end
endmodule

// File: rtl/seq_out_sel.sv
module seq_out_sel
  import seq_pkg::*;
(
  input  seq_state_t state,
  input  ctl_t       exec_w,
  output ctl_t       w
);
  always_comb begin
    w = ctl_idle();
    case (state)
      ST_INIT: begin
        w.clr  = 1'b1;
        w.mreq = 1'b0;
      end
      ST_FETCH: begin
        w.ir_ld = 1'b1;
        w.pc_ld = 1'b1;
      end
      ST_EXEC: w = exec_w;
      ST_STOP: w.mreq = 1'b0;
      default: w.mreq = 1'b0;
    endcase
  end
endmodule

// File: rtl/cpu_seq_ctrl.sv
module cpu_seq_ctrl
  import seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   opcode,
  input  logic              acc_neg,
  input  logic              acc_zero,
  output logic [ASEL_W-1:0] addr_sel,
  output logic              alub_sel,
  output logic              acc_src_sel,
  output logic              acc_ld,
  output logic              pc_ld,
  output logic              r_ld,
  output logic              ir_ld,
  output logic              acc_oe,
  output logic [FN_W-1:0]   alu_fn,
  output logic              mem_req,
  output logic              rd_nwr,
  output logic              clr
);
  seq_state_t state;
  logic       take;
  ctl_t       exec_w;
  ctl_t       out_w;

  seq_state u_state (
    .clk   (clk),
    .rst   (rst),
    .op    (opcode),
    .state (state)
  );

  seq_cond u_cond (
    .op   (opcode),
    .neg  (acc_neg),
    .zero (acc_zero),
    .take (take)
  );

  seq_exec_dec u_dec (
    .op   (opcode),
    .take (take),
    .w    (exec_w)
  );

  seq_out_sel u_sel (
    .state  (state),
    .exec_w (exec_w),
    .w      (out_w)
  );

  assign addr_sel    = out_w.asel;
  assign alub_sel    = out_w.bsel;
  assign acc_src_sel = out_w.asrc;
  assign acc_ld      = out_w.acc_ld;
  assign pc_ld       = out_w.pc_ld;
  assign r_ld        = out_w.r_ld;
  assign ir_ld       = out_w.ir_ld;
  assign acc_oe      = out_w.acc_oe;
  assign alu_fn      = out_w.fn;
  assign mem_req     = out_w.mreq;
  assign rd_nwr      = out_w.rnw;
  assign clr         = out_w.clr;
endmodule

// File: rtl/cpu_seq_ctrl_chk.sv
module cpu_seq_ctrl_chk
  import seq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ASEL_W-1:0] addr_sel,
  input logic              alub_sel,
  input logic              acc_src_sel,
  input logic              acc_ld,
  input logic              pc_ld,
  input logic              r_ld,
  input logic              ir_ld,
  input logic              acc_oe,
  input logic [FN_W-1:0]   alu_fn,
  input logic              mem_req,
  input logic              rd_nwr,
  input logic              clr
);
  always @(negedge clk) begin
    if (rst) begin
      AST_RESET_QUIET: assert (clr && !mem_req && !acc_ld && !pc_ld && !r_ld && !ir_ld && !acc_oe); // R1
    end
  end

  AST_CLEAR_ONCE: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!clr && ir_ld)); // R2

  AST_FETCH_WORD: assert property (@(posedge clk) disable iff (rst)
    ir_ld |-> (pc_ld && addr_sel == AS_PC && !alub_sel && alu_fn == FN_BINC &&
               mem_req && rd_nwr && !acc_ld && !r_ld && !acc_oe)); // R3

  AST_FETCH_THEN_EXEC: assert property (@(posedge clk) disable iff (rst)
    ir_ld |=> !ir_ld); // R4

  AST_STORE_WRITES: assert property (@(posedge clk) disable iff (rst)
    acc_oe |-> (mem_req && !rd_nwr && !acc_ld && !pc_ld)); // R6

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    (pc_ld && !ir_ld) |-> (addr_sel == AS_IRA && alu_fn == FN_PASSB && !alub_sel)); // R7

  AST_MEMSRC_INDEXED: assert property (@(posedge clk) disable iff (rst)
    acc_src_sel |-> (addr_sel == AS_REG && acc_ld && r_ld && rd_nwr)); // R9

  AST_STOP_ABSORB: assert property (@(posedge clk) disable iff (rst)
    (!mem_req && !clr) |=> (!mem_req && !clr && !acc_ld && !pc_ld && !r_ld && !ir_ld && !acc_oe)); // R10

  AST_NO_UNUSED_SEL: assert property (@(posedge clk) disable iff (rst)
    addr_sel != AS_NONE); // R12
endmodule

bind cpu_seq_ctrl cpu_seq_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .addr_sel    (addr_sel),
  .alub_sel    (alub_sel),
  .acc_src_sel (acc_src_sel),
  .acc_ld      (acc_ld),
  .pc_ld       (pc_ld),
  .r_ld        (r_ld),
  .ir_ld       (ir_ld),
  .acc_oe      (acc_oe),
  .alu_fn      (alu_fn),
  .mem_req     (mem_req),
  .rd_nwr      (rd_nwr),
  .clr         (clr)
);

// File: tb/tb_cpu_seq_ctrl.sv
module tb_cpu_seq_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] opcode;
  logic       acc_neg, acc_zero;
  logic [1:0] addr_sel;
  logic       alub_sel, acc_src_sel, acc_ld, pc_ld, r_ld, ir_ld, acc_oe;
  logic [2:0] alu_fn;
  logic       mem_req, rd_nwr, clr;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  cpu_seq_ctrl dut (
    .clk(clk), .rst(rst), .opcode(opcode), .acc_neg(acc_neg), .acc_zero(acc_zero),
    .addr_sel(addr_sel), .alub_sel(alub_sel), .acc_src_sel(acc_src_sel),
    .acc_ld(acc_ld), .pc_ld(pc_ld), .r_ld(r_ld), .ir_ld(ir_ld), .acc_oe(acc_oe),
    .alu_fn(alu_fn), .mem_req(mem_req), .rd_nwr(rd_nwr), .clr(clr)
  );

  // word layout: asel(2) bsel asrc acc pc r ir oe fn(3) mreq rnw clr
  localparam logic [14:0] W_INIT  = 15'b00_0_0_0000_0_000_0_1_1;
  localparam logic [14:0] W_FETCH = 15'b00_0_0_0101_0_000_1_1_0;
  localparam logic [14:0] W_STOP  = 15'b00_0_0_0000_0_000_0_1_0;

  // entry: opcode(4) neg zero expected_exec_word(15)
  localparam int NV = 19;
  localparam logic [20:0] VEC [0:NV-1] = '{
    {4'h0, 2'b00, 15'b11_1_0_1000_0_001_1_1_0},
    {4'h1, 2'b00, 15'b11_0_0_0000_1_000_1_0_0},
    {4'h2, 2'b01, 15'b11_1_0_1000_0_010_1_1_0},
    {4'h3, 2'b10, 15'b11_1_0_1000_0_011_1_1_0},
    {4'h4, 2'b10, 15'b11_0_0_0100_0_001_1_1_0},
    {4'h5, 2'b00, 15'b11_0_0_0100_0_001_1_1_0},
    {4'h5, 2'b10, 15'b11_0_0_0000_0_001_1_1_0},
    {4'h5, 2'b01, 15'b11_0_0_0100_0_001_1_1_0},
    {4'h6, 2'b00, 15'b11_0_0_0100_0_001_1_1_0},
    {4'h6, 2'b01, 15'b11_0_0_0000_0_001_1_1_0},
    {4'h6, 2'b10, 15'b11_0_0_0100_0_001_1_1_0},
    {4'h8, 2'b00, 15'b11_1_0_1000_0_100_1_1_0},
    {4'h9, 2'b11, 15'b11_1_0_1000_0_101_1_1_0},
    {4'hA, 2'b00, 15'b11_1_0_1000_0_110_1_1_0},
    {4'hB, 2'b00, 15'b11_0_0_0010_0_001_1_1_0},
    {4'hC, 2'b00, 15'b01_0_1_1010_0_000_1_1_0},
    {4'hD, 2'b01, 15'b01_0_0_0010_1_000_1_0_0},
    {4'hE, 2'b00, 15'b00_0_0_0000_0_000_1_1_0},
    {4'hF, 2'b11, 15'b00_0_0_0000_0_000_1_1_0}
  };

  function automatic string tag_of(logic [3:0] op);
    case (op)
      4'h1:             return "R6";
      4'h4, 4'h5, 4'h6: return "R7";
      4'hB:             return "R8";
      4'hC, 4'hD:       return "R9/R12";
      4'hE, 4'hF:       return "R11";
      default:          return "R5";
    endcase
  endfunction

  task automatic chk(input string req, input logic [14:0] exp);
    logic [14:0] got;
    got = {addr_sel, alub_sel, acc_src_sel, acc_ld, pc_ld, r_ld, ir_ld, acc_oe,
           alu_fn, mem_req, rd_nwr, clr};
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; opcode = 4'h0; acc_neg = 1'b0; acc_zero = 1'b0;
    repeat (2) @(negedge clk);
    #2 chk("R1 reset", W_INIT);
    @(negedge clk); rst = 1'b0;
    #2 chk("R2 clear", W_INIT);
    @(negedge clk);

    // table walk: fetch then execute for each vector
    for (int i = 0; i < NV; i++) begin
      opcode   = VEC[i][20:17];
      acc_neg  = VEC[i][16];
      acc_zero = VEC[i][15];
      #2 chk("R3/R4 fetch", W_FETCH);
      @(negedge clk);
      #2 chk(tag_of(opcode), VEC[i][14:0]);
      @(negedge clk);
    end

    // halt and the absorbing stop state, R10
    opcode = 4'h7;
    #2 chk("R4 fetch before halt", W_FETCH);
    @(negedge clk);
    #2 chk("R10 halt exec", W_STOP);
    @(negedge clk);
    #2 chk("R10 stop", W_STOP);
    for (int k = 0; k < 4; k++) begin
      opcode   = 4'(k * 5);
      acc_neg  = k[0];
      acc_zero = k[1];
      @(negedge clk);
      #2 chk("R10 stop ignores inputs", W_STOP);
    end

    // asynchronous reset from stop, R1
    #3 rst = 1'b1;
    #1 chk("R1 async reset from stop", W_INIT);
    @(negedge clk); rst = 1'b0;
    #2 chk("R2 clear after stop", W_INIT);
    @(negedge clk);
    opcode = 4'h0; acc_neg = 1'b0; acc_zero = 1'b0;
    #2 chk("R3 fetch after reset", W_FETCH);
    @(negedge clk);
    // reset in the middle of an execute phase
    #3 rst = 1'b1;
    #1 chk("R1 async reset in exec", W_INIT);
    @(negedge clk); rst = 1'b0;
    #2 chk("R2 single clear cycle", W_INIT);
    @(negedge clk);
    #2 chk("R2 fetch follows clear", W_FETCH);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule